// File: doc/BRIEF.md
# I2C Bus Event Status and Interrupt Mask Unit

This block sits beside the byte engine of an I2C master. The byte engine raises single-cycle pulses when a bus event occurs. There are four such events: the wait point after the eighth SCL falling edge, a missing acknowledge at the ninth clock, the end of a data transfer, and a lost arbitration. The transfer-end pulse also comes right after a START condition, once the data register can accept the address byte. The unit holds each event as a sticky flag until software clears it.

The same status word also carries live information. It shows the synchronized SCL and SDA levels and a bus-busy bit, which covers the span from a START condition to a STOP condition. A four-bit enable register gates the flags into a single interrupt line.

Software clears flags by writing the status word. A bit written as zero clears its flag, and a bit written as one keeps the flag as it is. This lets the driver clear the arbitration-lost and acknowledge-error flags while a pending wait flag stays set.

Top module: `i2c_evt_irq_unit`

## Requirements
- R1: After reset, the four event flags, the busy bit, the enable register and `irq` are all zero.
- R2: A pulse sets its own flag in the status word. The bit positions are: transfer end at bit 0, wait at bit 1, acknowledge error at bit 2 and arbitration lost at bit 3. The flag is visible in the cycle after the pulse.
- R3: A set flag stays set while no status write occurs.
- R4: Writing the status word clears each flag whose bit is written as 0. A bit written as 1 leaves its flag as it was and never sets a clear flag.
- R5: Flags clear independently. For example, writing 0xF3 clears the arbitration-lost and acknowledge-error flags and keeps the wait and transfer-end flags.
- R6: If a pulse arrives in the same cycle as a write that clears its flag, the flag is set after that cycle.
- R7: Bit 4 (busy) is set in the cycle after `start_det` and is cleared in the cycle after `stop_det`. If both arrive in the same cycle, busy ends up set.
- R8: Bit 7 follows `scl_in` and bit 6 follows `sda_in` in the same cycle, and bit 5 always reads 0. Writing the status word has no effect on bits 7 to 4.
- R9: A write loads enable bits 3:0 from `wdata[3:0]`. The enable bits use the same positions as the flags. `enable_rdata[7:4]` always reads 0.
- R10: `irq` is high exactly when some flag and its enable bit are both set. It rises in the cycle after an enabled event, and it falls in the cycle after the flag is cleared or masked.
- R11: Writing 0 to the enable register masks every interrupt. Writing 0 to the status word clears every flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_xfer_end | input | 1 | Transfer-end pulse |
| ev_wait | input | 1 | Wait-point pulse (8th SCL fall) |
| ev_ack_err | input | 1 | Missing-acknowledge pulse (9th clock) |
| ev_arb_lost | input | 1 | Arbitration-lost pulse |
| start_det | input | 1 | START condition seen |
| stop_det | input | 1 | STOP condition seen |
| scl_in | input | 1 | Synchronized SCL level |
| sda_in | input | 1 | Synchronized SDA level |
| status_we | input | 1 | Status word write strobe |
| enable_we | input | 1 | Enable register write strobe |
| wdata | input | 8 | Write data for both registers |
| status_rdata | output | 8 | Status word read value |
| enable_rdata | output | 8 | Enable register read value |
| irq | output | 1 | Interrupt request |

## Verification
The flags, the busy bit, the enable bits and `irq` all come from one register stage. An input change is therefore due exactly one clock later. The SCL and SDA monitor bits are combinational and show in the same cycle.

The bench drives every stimulus on a falling edge. For each stimulus it queues the expected status word, enable value and `irq`, computed from the requirements. The monitor samples shortly after the next rising edge, while the stimulus is still held. At that moment both the registered results and the live line bits are due, so one comparison per queued item covers both timings.

// File: rtl/i2cism_pkg.sv
package i2cism_pkg;
  localparam int REG_W   = 8;
  localparam int NUM_EVT = 4;
  // event flag positions (also enable positions)
  localparam int EVT_END = 0;
  localparam int EVT_WAIT = 1;
  localparam int EVT_ACK = 2;
  localparam int EVT_ARB = 3;
  // live / level bits
  localparam int BIT_BUSY = 4;
  localparam int BIT_SDA  = 6;
  localparam int BIT_SCL  = 7;
  typedef logic [NUM_EVT-1:0] evt_vec_t;
endpackage

// File: rtl/evt_flag_bank.sv
module evt_flag_bank #(
  parameter int NUM_EVT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt,
  input  logic               clr_en,
  input  logic [NUM_EVT-1:0] keep_mask,
  output logic [NUM_EVT-1:0] flags
);
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
    logic flg_q, flg_d, flg_ce;

    always_comb begin
      flg_ce = evt[i] | clr_en;
      flg_d  = evt[i] | (flg_q & keep_mask[i]) | (flg_q & ~clr_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flg_q <= 1'b0;
      else if (flg_ce) flg_q <= flg_d;
    end

    assign flags[i] = flg_q;

    assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> flags[i]);
    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      flags[i] && !clr_en |=> flags[i]);
    assert_zero_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en && !keep_mask[i] && !evt[i] |=> !flags[i]);
    assert_one_no_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !flags[i] && !evt[i] |=> !flags[i]);
    assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] && clr_en && !keep_mask[i] |=> flags[i]);
  end

  assert_clear_all_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en && keep_mask == '0 && evt == '0 |=> flags == '0);
endmodule

// File: rtl/bus_busy_track.sv
module bus_busy_track (
  input  logic clk,
  input  logic rst_n,
  input  logic start_det,
  input  logic stop_det,
  output logic busy
);
  logic busy_q, busy_d, busy_ce;

  always_comb begin
    busy_ce = start_det | stop_det;
    busy_d  = start_det;  // start wins over a coincident stop
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busy_q <= 1'b0;
    else if (busy_ce) busy_q <= busy_d;
  end

  assign busy = busy_q;

  assert_start_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> busy);
  assert_stop_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det && !start_det |=> !busy);
  assert_busy_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !start_det && !stop_det |=> $stable(busy));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int NUM_EVT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [NUM_EVT-1:0] wdata,
  input  logic [NUM_EVT-1:0] flags,
  output logic [NUM_EVT-1:0] enable,
  output logic               irq
);
  logic [NUM_EVT-1:0] en_q, en_d;

  always_comb en_d = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= en_d;
  end

  assign enable = en_q;
  assign irq    = |(flags & en_q);

  assert_mask_all_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wdata == '0 |=> !irq);
  assert_en_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(enable));
endmodule

// File: rtl/i2c_evt_irq_unit.sv
module i2c_evt_irq_unit
  import i2cism_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_xfer_end,
  input  logic             ev_wait,
  input  logic             ev_ack_err,
  input  logic             ev_arb_lost,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             status_we,
  input  logic             enable_we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] status_rdata,
  output logic [REG_W-1:0] enable_rdata,
  output logic             irq
);
  evt_vec_t evt, flags, enable;
  logic     busy;
  logic     unused_hi;

  always_comb begin
    evt           = '0;
    evt[EVT_END]  = ev_xfer_end;
    evt[EVT_WAIT] = ev_wait;
    evt[EVT_ACK]  = ev_ack_err;
    evt[EVT_ARB]  = ev_arb_lost;
  end

  assign unused_hi = ^wdata[REG_W-1:NUM_EVT];

  evt_flag_bank #(.NUM_EVT(NUM_EVT)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt), .clr_en(status_we),
    .keep_mask(wdata[NUM_EVT-1:0]), .flags(flags)
  );

  bus_busy_track u_busy (
    .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
    .busy(busy)
  );

  irq_mask_reg #(.NUM_EVT(NUM_EVT)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_en(enable_we), .wdata(wdata[NUM_EVT-1:0]),
    .flags(flags), .enable(enable), .irq(irq)
  );

  always_comb begin
    status_rdata                = '0;
    status_rdata[NUM_EVT-1:0]   = flags;
    status_rdata[BIT_BUSY]      = busy;
    status_rdata[BIT_SDA]       = sda_in;
    status_rdata[BIT_SCL]       = scl_in;
    enable_rdata                = '0;
    enable_rdata[NUM_EVT-1:0]   = enable;
  end

  assert_irq_rises_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wait && enable[EVT_WAIT] && !enable_we |=> irq);
  assert_bit5_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status_rdata[5] == 1'b0);
endmodule

// File: tb/i2c_evt_irq_unit_tb.sv
module i2c_evt_irq_unit_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic ev_xfer_end, ev_wait, ev_ack_err, ev_arb_lost;
  logic start_det, stop_det, scl_in, sda_in, status_we, enable_we;
  logic [7:0] wdata, status_rdata, enable_rdata;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] st;
    logic [7:0] en;
    logic       irq;
    string      tag;
  } exp_t;
  exp_t q[$];

  logic [3:0] flags_m = 4'h0;
  logic [3:0] en_m = 4'h0;
  logic       busy_m = 1'b0;

  always #2 clk = ~clk;

  i2c_evt_irq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .ev_xfer_end(ev_xfer_end), .ev_wait(ev_wait),
    .ev_ack_err(ev_ack_err), .ev_arb_lost(ev_arb_lost), .start_det(start_det),
    .stop_det(stop_det), .scl_in(scl_in), .sda_in(sda_in), .status_we(status_we),
    .enable_we(enable_we), .wdata(wdata), .status_rdata(status_rdata),
    .enable_rdata(enable_rdata), .irq(irq)
  );

  task automatic compare(input exp_t e);
    checks++;
    if (status_rdata !== e.st || enable_rdata !== e.en || irq !== e.irq) begin
      errors++;
      $display("FAIL %s: st=%h en=%h irq=%b expected st=%h en=%h irq=%b",
               e.tag, status_rdata, enable_rdata, irq, e.st, e.en, e.irq);
    end
  endtask

  // driver: ev = {arb, ack, wait, end}
  task automatic step(input logic [3:0] ev, input logic sta, input logic sto,
                      input logic scl, input logic sda, input logic ws,
                      input logic we, input logic [7:0] d, input string tag);
    exp_t e;
    @(negedge clk);
    {ev_arb_lost, ev_ack_err, ev_wait, ev_xfer_end} = ev;
    start_det = sta; stop_det = sto; scl_in = scl; sda_in = sda;
    status_we = ws; enable_we = we; wdata = d;
    flags_m = ev | (flags_m & (ws ? d[3:0] : 4'hF));
    busy_m  = sta ? 1'b1 : (sto ? 1'b0 : busy_m);
    if (we) en_m = d[3:0];
    e.st  = {scl, sda, 1'b0, busy_m, flags_m};
    e.en  = {4'h0, en_m};
    e.irq = |(flags_m & en_m);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(4'h0, 0, 0, 1, 1, 0, 0, 8'h00, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) compare(q.pop_front());
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    {ev_arb_lost, ev_ack_err, ev_wait, ev_xfer_end} = 4'h0;
    start_det = 0; stop_det = 0; scl_in = 1; sda_in = 1;
    status_we = 0; enable_we = 0; wdata = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    begin
      exp_t e;
      e.st = 8'hC0; e.en = 8'h00; e.irq = 1'b0; e.tag = "R1 reset";
      compare(e);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R2: each event to its own bit
    step(4'b0010, 0, 0, 1, 1, 0, 0, 8'h00, "R2 wait bit1");
    step(4'b0001, 0, 0, 1, 1, 0, 0, 8'h00, "R2 end bit0");
    step(4'b0100, 0, 0, 1, 1, 0, 0, 8'h00, "R2 ack bit2");
    step(4'b1000, 0, 0, 1, 1, 0, 0, 8'h00, "R2 arb bit3");
    idle("R3 sticky");
    idle("R3 sticky");
    // R4: zero clears, one keeps
    step(4'h0, 0, 0, 1, 1, 1, 0, 8'hFB, "R4 clear ack");
    step(4'h0, 0, 0, 1, 1, 1, 0, 8'hFF, "R4 ones keep");
    step(4'h0, 0, 0, 1, 1, 1, 0, 8'hFE, "R4 clear end");
    step(4'h0, 0, 0, 1, 1, 1, 0, 8'hFF, "R4 ones no set");
    // R5: selective clear keeps wait
    step(4'b1111, 0, 0, 1, 1, 0, 0, 8'h00, "R5 set all");
    step(4'h0, 0, 0, 1, 1, 1, 0, 8'hF3, "R5 clear arb ack");
    // R6: event beats clear
    step(4'b0010, 0, 0, 1, 1, 1, 0, 8'h00, "R6 event wins");
    idle("R6 held");
    // R7: busy
    step(4'h0, 1, 0, 1, 0, 0, 0, 8'h00, "R7 start");
    step(4'h0, 0, 0, 0, 0, 0, 0, 8'h00, "R7 holds");
    step(4'h0, 0, 1, 1, 0, 0, 0, 8'h00, "R7 stop");
    step(4'h0, 1, 1, 1, 1, 0, 0, 8'h00, "R7 start and stop");
    // R8: live lines, bits 7..4 unaffected by writes
    step(4'h0, 0, 0, 0, 1, 1, 0, 8'h0F, "R8 scl low write hi zero");
    step(4'h0, 0, 0, 1, 0, 1, 0, 8'hFF, "R8 sda low write hi one");
    step(4'h0, 0, 1, 0, 0, 0, 0, 8'h00, "R8 both low");
    // R9: enable register
    step(4'h0, 0, 0, 1, 1, 0, 1, 8'hF5, "R9 enable upper zero");
    step(4'h0, 0, 0, 1, 1, 0, 1, 8'h00, "R9 enable zero");
    // R10: irq
    step(4'h0, 0, 0, 1, 1, 1, 1, 8'h02, "R10 enable wait");
    step(4'b0001, 0, 0, 1, 1, 0, 0, 8'h00, "R10 masked event");
    step(4'b0010, 0, 0, 1, 1, 0, 0, 8'h00, "R10 irq rises");
    step(4'h0, 0, 0, 1, 1, 1, 0, 8'hFD, "R10 clear drops");
    step(4'h0, 0, 0, 1, 1, 0, 1, 8'h01, "R10 enable end");
    step(4'h0, 0, 0, 1, 1, 0, 1, 8'h08, "R10 mask end");
    // R11: zero masks all, zero clears all
    step(4'b1111, 0, 0, 1, 1, 0, 1, 8'h0F, "R11 all set enabled");
    step(4'h0, 0, 0, 1, 1, 0, 1, 8'h00, "R11 mask all");
    step(4'h0, 0, 0, 1, 1, 1, 0, 8'h00, "R11 clear all");
    idle("R11 stays clear");
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule